// File: doc/BRIEF.md
# XOR Chain Test Mode Controller

This block sits between a chip's core logic and its pad ring and gives board test equipment a way to probe solder connectivity. In normal operation it is transparent: core output data and output enables pass straight to the pads. On a synchronous load strobe it can switch the pad ring into one of two test states. The first is a global float state, in which every pad driver is switched off. The second selects one of four XOR chains.

When a chain is selected, its member pads become pure inputs. Their sampled values are folded together with a constant 1 into a single parity bit, and that bit drives the chain's dedicated output pad. Every other pad on the chip has its driver disabled. A tester applies walking patterns to the member pins and watches the output pin toggle. A pin stuck high, stuck low or left open shows up as a wrong parity.

Chain membership and the output pad of each chain are parameters given as bit masks over a configurable pad count. With the defaults (16 pads), chain k has member pads 4k, 4k+1 and 4k+2, and its output pad is pad 4k+3.

Top module: `pad_xchain_ctl`

## Requirements
- R1: While `rst_n` is low, and after it rises, the stored mode is normal, so `pad_out` equals `core_out` and `pad_oe` equals `core_oe` until a load occurs.
- R2: In normal mode, `pad_out` equals `core_out` and `pad_oe` equals `core_oe` in the same cycle, for any input pattern.
- R3: The mode changes only at a rising clock edge where `mode_load` is 1. A changed `mode_sel` with `mode_load` at 0 has no effect on the pads.
- R4: The `mode_sel` encoding is: 0 selects normal, 1 selects float, 2 to 5 select chain 0 to chain 3, and 6 or 7 select float. The new mode shows at the pads from the edge that captured it.
- R5: In float mode, `pad_oe` is all zeros.
- R6: In chain mode k, `pad_oe` has exactly one bit set, and that bit is the output pad of chain k (pad 4k+3 by default).
- R7: In chain mode k, the output pad's `pad_out` bit equals 1 XOR the parity of the `pad_in` bits of chain k's members. With all members at 0 the bit is 1, and each further member set to 1 flips it.
- R8: In chain mode k, `pad_in` of pads outside chain k's member set, including chain k's own output pad, does not affect `pad_out`.
- R9: In float mode and in every chain mode, each `pad_out` bit whose `pad_oe` bit is 0 is driven 0, and `core_out` and `core_oe` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; returns the mode to normal |
| mode_load | input | 1 | Synchronous strobe that captures `mode_sel` |
| mode_sel | input | 3 | Requested mode code |
| pad_in | input | NUM_PADS | Values sampled from the pads |
| core_out | input | NUM_PADS | Core output data per pad |
| core_oe | input | NUM_PADS | Core output enable per pad |
| pad_out | output | NUM_PADS | Data driven toward the pad buffers |
| pad_oe | output | NUM_PADS | Output enable toward the pad buffers |

## Verification
A mode load and a live parity fold can coincide. In the same cycle that the strobe captures a chain code, the pad input pattern is also changed. The bench drives both on one falling edge and checks after the capturing rising edge. The output bit must be the parity of the new inputs over the newly selected chain's members, with only that chain's output enabled. A second case switches directly from one chain to another while the inputs are still toggling. This shows that the previous chain's output pad is released in the same cycle that the new one starts driving.

// File: rtl/xchain_pkg.sv
package xchain_pkg;

    localparam int NUM_CHAINS = 4;
    localparam int SEL_W      = 3;

    typedef enum logic [SEL_W-1:0] {
        MODE_NORMAL = 3'd0,
        MODE_FLOAT  = 3'd1,
        MODE_CH0    = 3'd2,
        MODE_CH1    = 3'd3,
        MODE_CH2    = 3'd4,
        MODE_CH3    = 3'd5
    } mode_e;

    typedef struct packed {
        mode_e mode;
    } mode_state_t;

    function automatic mode_e decode_sel(input logic [SEL_W-1:0] sel);
        mode_e m;
        case (sel)
            3'd0:    m = MODE_NORMAL;
            3'd2:    m = MODE_CH0;
            3'd3:    m = MODE_CH1;
            3'd4:    m = MODE_CH2;
            3'd5:    m = MODE_CH3;
            default: m = MODE_FLOAT;
        endcase
        return m;
    endfunction

    function automatic logic is_chain(input mode_e m);
        return (m == MODE_CH0) || (m == MODE_CH1) ||
               (m == MODE_CH2) || (m == MODE_CH3);
    endfunction

endpackage

// File: rtl/xchain_mode_reg.sv
module xchain_mode_reg
    import xchain_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [SEL_W-1:0] sel_i,
    output mode_e            mode_o
);

    mode_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.mode = decode_sel(sel_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.mode <= MODE_NORMAL;
        end else begin
            state_q <= state_d;
        end
    end

    assign mode_o = state_q.mode;

endmodule

// File: rtl/xchain_fold.sv
module xchain_fold #(
    parameter int                  NUM_PADS = 16,
    parameter logic [NUM_PADS-1:0] MEMBERS  = '0
) (
    input  logic [NUM_PADS-1:0] pad_in_i,
    output logic                parity_o
);

    logic [NUM_PADS-1:0] picked;

    always_comb begin
        picked   = pad_in_i & MEMBERS;
        parity_o = 1'b1 ^ (^picked);
    end

endmodule

// File: rtl/xchain_pad_mux.sv
module xchain_pad_mux
    import xchain_pkg::*;
#(
    parameter int                                  NUM_PADS = 16,
    parameter logic [NUM_CHAINS-1:0][NUM_PADS-1:0] OUT_MASK = '0
) (
    input  mode_e                 mode_i,
    input  logic [NUM_CHAINS-1:0] parity_i,
    input  logic [NUM_PADS-1:0]   core_out_i,
    input  logic [NUM_PADS-1:0]   core_oe_i,
    output logic [NUM_PADS-1:0]   pad_out_o,
    output logic [NUM_PADS-1:0]   pad_oe_o
);

    localparam int IDX_W = $clog2(NUM_CHAINS);

    logic [SEL_W-1:0] offset;
    logic [IDX_W-1:0] chain_idx;

    always_comb begin
        offset    = SEL_W'(mode_i) - SEL_W'(MODE_CH0);
        chain_idx = offset[IDX_W-1:0];
        pad_out_o = '0;
        pad_oe_o  = '0;
        if (mode_i == MODE_NORMAL) begin
            pad_out_o = core_out_i;
            pad_oe_o  = core_oe_i;
        end else if (is_chain(mode_i)) begin
            for (int c = 0; c < NUM_CHAINS; c++) begin
                if (chain_idx == IDX_W'(c)) begin
                    pad_oe_o  = OUT_MASK[c];
                    pad_out_o = OUT_MASK[c] & {NUM_PADS{parity_i[c]}};
                end
            end
        end
    end

endmodule

// File: rtl/pad_xchain_ctl.sv
module pad_xchain_ctl
    import xchain_pkg::*;
#(
    parameter int                                  NUM_PADS    = 16,
    parameter logic [NUM_CHAINS-1:0][NUM_PADS-1:0] MEMBER_MASK = {16'h7000, 16'h0700, 16'h0070, 16'h0007},
    parameter logic [NUM_CHAINS-1:0][NUM_PADS-1:0] OUT_MASK    = {16'h8000, 16'h0800, 16'h0080, 16'h0008}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_load,
    input  logic [2:0]          mode_sel,
    input  logic [NUM_PADS-1:0] pad_in,
    input  logic [NUM_PADS-1:0] core_out,
    input  logic [NUM_PADS-1:0] core_oe,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] pad_oe
);

    mode_e                 mode_q;
    logic [NUM_CHAINS-1:0] parity;

    xchain_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (mode_load),
        .sel_i  (mode_sel),
        .mode_o (mode_q)
    );

    for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
        xchain_fold #(
            .NUM_PADS (NUM_PADS),
            .MEMBERS  (MEMBER_MASK[c])
        ) u_fold (
            .pad_in_i (pad_in),
            .parity_o (parity[c])
        );
    end

    xchain_pad_mux #(
        .NUM_PADS (NUM_PADS),
        .OUT_MASK (OUT_MASK)
    ) u_mux (
        .mode_i     (mode_q),
        .parity_i   (parity),
        .core_out_i (core_out),
        .core_oe_i  (core_oe),
        .pad_out_o  (pad_out),
        .pad_oe_o   (pad_oe)
    );

endmodule

// File: rtl/pad_xchain_ctl_chk.sv
module pad_xchain_ctl_chk
    import xchain_pkg::*;
#(
    parameter int NUM_PADS = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mode_load,
    input logic [2:0]          mode_sel,
    input logic [NUM_PADS-1:0] core_out,
    input logic [NUM_PADS-1:0] core_oe,
    input logic [NUM_PADS-1:0] pad_out,
    input logic [NUM_PADS-1:0] pad_oe,
    input mode_e               mode_q
);

    assert_normal_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_NORMAL) |-> (pad_out == core_out) && (pad_oe == core_oe));

    assert_hold_without_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_load |=> $stable(mode_q));

    assert_high_codes_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_load && mode_sel >= 3'd6) |=> (mode_q == MODE_FLOAT));

    assert_float_all_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_FLOAT) |-> (pad_oe == '0));

    assert_single_driver_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_chain(mode_q) |-> ($countones(pad_oe) == 1));

    assert_quiet_undriven_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_NORMAL) |-> ((pad_out & ~pad_oe) == '0));

endmodule

bind pad_xchain_ctl pad_xchain_ctl_chk #(.NUM_PADS(NUM_PADS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_load (mode_load),
    .mode_sel  (mode_sel),
    .core_out  (core_out),
    .core_oe   (core_oe),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .mode_q    (mode_q)
);

// File: tb/sim_pad_xchain_ctl.sv
`timescale 1ns/1ps
module sim_pad_xchain_ctl;

    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_load = 1'b0;
    logic [2:0]   mode_sel = 3'd0;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] core_out = '0;
    logic [N-1:0] core_oe = '0;
    logic [N-1:0] pad_out;
    logic [N-1:0] pad_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pad_xchain_ctl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_load (mode_load),
        .mode_sel  (mode_sel),
        .pad_in    (pad_in),
        .core_out  (core_out),
        .core_oe   (core_oe),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    function automatic logic [N-1:0] members(input int k);
        return N'(16'h0007) << (4 * k);
    endfunction

    function automatic logic [N-1:0] out_pad(input int k);
        return N'(16'h0008) << (4 * k);
    endfunction

    function automatic logic [N-1:0] exp_chain_out(input int k, input logic [N-1:0] pin);
        logic bitv;
        bitv = 1'b1;
        for (int i = 0; i < N; i++) if (members(k)[i]) bitv = bitv ^ pin[i];
        return bitv ? out_pad(k) : '0;
    endfunction

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_mode(input logic [2:0] sel);
        @(negedge clk);
        mode_sel  = sel;
        mode_load = 1'b1;
        @(negedge clk);
        mode_load = 1'b0;
        #1;
    endtask

    task automatic test_reset;
        core_out = 16'hA5C3;
        core_oe  = 16'h0FF0;
        #1;
        chk("R1 reset out", pad_out, 16'hA5C3);
        chk("R1 reset oe", pad_oe, 16'h0FF0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset oe", pad_oe, 16'h0FF0);
    endtask

    task automatic test_normal;
        logic [N-1:0] pats [3] = '{16'hFFFF, 16'h1234, 16'h0000};
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            core_out = pats[i];
            core_oe  = ~pats[i];
            pad_in   = pats[i] ^ 16'h5555;
            #1;
            chk("R2 normal out", pad_out, pats[i]);
            chk("R2 normal oe", pad_oe, ~pats[i]);
        end
    endtask

    task automatic test_no_load;
        @(negedge clk);
        mode_sel = 3'd1;
        core_oe  = 16'hFFFF;
        @(negedge clk);
        @(negedge clk);
        chk("R3 sel without load", pad_oe, 16'hFFFF);
    endtask

    task automatic test_float;
        logic [2:0] codes [3] = '{3'd1, 3'd6, 3'd7};
        core_oe  = 16'hFFFF;
        core_out = 16'hFFFF;
        for (int i = 0; i < 3; i++) begin
            load_mode(codes[i]);
            chk("R5 float oe", pad_oe, '0);
            chk("R4 float code out R9", pad_out, '0);
        end
    endtask

    task automatic test_chains;
        core_oe  = 16'hFFFF;
        core_out = 16'hFFFF;
        for (int k = 0; k < 4; k++) begin
            pad_in = '0;
            load_mode(3'(k + 2));
            chk("R6 chain oe", pad_oe, out_pad(k));
            chk("R4 chain code", pad_oe, out_pad(k));
            for (int v = 0; v <= 3; v++) begin
                logic [N-1:0] pin;
                pin = '0;
                for (int b = 0; b < v; b++) pin[4 * k + b] = 1'b1;
                pad_in = pin;
                #1;
                chk("R7 walking parity", pad_out, exp_chain_out(k, pin));
                pad_in = pin | ~members(k);
                #1;
                chk("R8 outside pads ignored", pad_out, exp_chain_out(k, pin));
            end
        end
    endtask

    task automatic test_coincide;
        load_mode(3'd2);
        pad_in = 16'h0000;
        @(negedge clk);
        mode_sel  = 3'd4;
        mode_load = 1'b1;
        pad_in    = 16'h0100;
        @(negedge clk);
        mode_load = 1'b0;
        #1;
        chk("R6 switch oe", pad_oe, 16'h0800);
        chk("R7 switch fold", pad_out, 16'h0000);
        pad_in = 16'h0300;
        #1;
        chk("R7 switch fold 2", pad_out, 16'h0800);
    endtask

    task automatic test_back_and_reset;
        core_out = 16'h00FF;
        core_oe  = 16'hF00F;
        load_mode(3'd0);
        chk("R4 back to normal", pad_out, 16'h00FF);
        load_mode(3'd5);
        chk("R6 chain3", pad_oe, 16'h8000);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 reset from chain", pad_oe, 16'hF00F);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 stays normal", pad_out, 16'h00FF);
    endtask

    initial begin
        test_reset();
        test_normal();
        test_no_load();
        test_float();
        test_chains();
        test_coincide();
        test_back_and_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule